// File: doc/BRIEF.md
# External Memory Wait-State Sequencer

This block times accesses to external static memory in two address areas. A
control register holds a separate 5-bit wait count for each area. When a request
arrives in the idle state, the block latches the wait count of the selected area.
It then drives chip-select and a read or write strobe for that many cycles. In the
last strobe cycle it pulses a completion flag. After that it can keep chip-select
asserted for up to two trailing cycles with the strobes low. These trailing cycles
lengthen data hold and bus release. They do not lengthen the access that the
requester sees.

A request flagged as dynamic-memory is not timed. The block forwards it as a
one-cycle pulse and does not touch the static-memory bus or busy. A programmed
wait count of zero is treated as one wait state. Requests that arrive while busy
is high are ignored. A requester that holds its request high therefore gets
back-to-back accesses, with one idle cycle between them.

Top module: `ext_wait_seq`

## Requirements
- R1: After reset, cfg_rdata reads 10'h3FF (both wait fields 31), and busy, bus_cs, rd_stb, wr_stb, done and dram_fwd are all low.
- R2: A write with cfg_we loads cfg_wdata into the register in one clock. Bits 4..0 are the area-0 wait count and bits 9..5 are the area-1 wait count. cfg_rdata shows the new value in the next cycle.
- R3: A static access accepted at clock edge E drives bus_cs and exactly one strobe from the cycle after E, for exactly W cycles, where W is the effective wait count of the area that req_area selects (0 = area 0, 1 = area 1). The strobe is rd_stb when req_write=0 and wr_stb when req_write=1.
- R4: done is high for exactly one cycle per access, namely the last cycle in which the strobe is high.
- R5: After the strobe falls, bus_cs stays high with both strobes low for T trailing cycles: T=0 for W of 1 to 3, T=1 for W of 4 to 7, and T=2 for W of 8 to 31.
- R6: A programmed wait count of 0 behaves exactly as a count of 1 (W=1, T=0).
- R7: busy is high for every cycle in which bus_cs is high, which is W+T cycles, and low otherwise. A request while busy is high is ignored and does not change the running access.
- R8: The wait count is latched at acceptance. A register write during an access leaves that access unchanged and applies from the next access.
- R9: A request with req_dram=1 in the idle state produces a one-cycle dram_fwd pulse in the next cycle, with busy, bus_cs and both strobes staying low.
- R10: If req stays high, the next access is accepted at the first edge on which the sequencer is idle. This leaves exactly one cycle with bus_cs low between two accesses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Control register write enable |
| cfg_wdata | input | 10 | Control register write data |
| cfg_rdata | output | 10 | Control register read-back |
| req | input | 1 | Access request, sampled while idle |
| req_area | input | 1 | Area select: 0 or 1 |
| req_write | input | 1 | 1 = write access, 0 = read access |
| req_dram | input | 1 | 1 = dynamic-memory access, forwarded and not timed |
| bus_cs | output | 1 | Chip-select, high through the access and trailing cycles |
| rd_stb | output | 1 | Read strobe |
| wr_stb | output | 1 | Write strobe |
| done | output | 1 | Completion pulse in the last strobe cycle |
| busy | output | 1 | Sequencer occupied |
| dram_fwd | output | 1 | One-cycle forward pulse for a dynamic-memory request |

## Verification
The bench builds the block with its default parameters: a 5-bit wait field, two areas and trailing thresholds of 4 and 8. With these values every wait count from 0 to 31 can be reached, including all three trailing lengths and both sides of each threshold. The full 33-cycle occupancy that follows reset is also measured. A 1-bit area select is enough to switch between the two fields, so each area can be checked on its own and for mix-ups between the areas.

// File: rtl/ews_pkg.sv
package ews_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ACC  = 2'd1,
    ST_TRL  = 2'd2
  } ews_state_t;
endpackage

// File: rtl/ews_cfg_reg.sv
module ews_cfg_reg #(
  parameter int WAIT_W = 5,
  parameter int AREAS  = 2,
  localparam int CFG_W  = WAIT_W * AREAS,
  localparam int AREA_W = (AREAS > 1) ? $clog2(AREAS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [CFG_W-1:0]  wdata,
  output logic [CFG_W-1:0]  rdata,
  input  logic [AREA_W-1:0] sel,
  output logic [WAIT_W-1:0] sel_wait
);
  logic [WAIT_W-1:0] field [AREAS];

  for (genvar a = 0; a < AREAS; a++) begin : g_area
    always_ff @(posedge clk) begin
      if (rst)
        field[a] <= '1;
      else if (we)
        field[a] <= wdata[a*WAIT_W +: WAIT_W];
    end
    assign rdata[a*WAIT_W +: WAIT_W] = field[a];
  end

  assign sel_wait = field[sel];
endmodule

// File: rtl/ews_wait_decode.sv
module ews_wait_decode #(
  parameter int WAIT_W    = 5,
  parameter int ONE_TRAIL = 4,
  parameter int TWO_TRAIL = 8
) (
  input  logic [WAIT_W-1:0] raw,
  output logic [WAIT_W-1:0] eff,
  output logic [1:0]        trail
);
  always_comb begin
    eff = (raw == '0) ? WAIT_W'(1) : raw;
    if (32'(eff) >= TWO_TRAIL)
      trail = 2'd2;
    else if (32'(eff) >= ONE_TRAIL)
      trail = 2'd1;
    else
      trail = 2'd0;
  end
endmodule

// File: rtl/ews_sequencer.sv
module ews_sequencer
  import ews_pkg::*;
#(
  parameter int WAIT_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req,
  input  logic              req_write,
  input  logic              req_dram,
  input  logic [WAIT_W-1:0] eff,
  input  logic [1:0]        trail,
  output logic              bus_cs,
  output logic              rd_stb,
  output logic              wr_stb,
  output logic              done,
  output logic              busy,
  output logic              dram_fwd
);
  ews_state_t        state;
  logic [WAIT_W-1:0] cnt;
  logic [1:0]        trl_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      trl_q    <= '0;
      bus_cs   <= 1'b0;
      rd_stb   <= 1'b0;
      wr_stb   <= 1'b0;
      done     <= 1'b0;
      busy     <= 1'b0;
      dram_fwd <= 1'b0;
    end else begin
      dram_fwd <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (req && req_dram) begin
            dram_fwd <= 1'b1;
          end else if (req) begin
            state  <= ST_ACC;
            cnt    <= eff - WAIT_W'(1);
            trl_q  <= trail;
            bus_cs <= 1'b1;
            busy   <= 1'b1;
            rd_stb <= !req_write;
            wr_stb <= req_write;
            done   <= (eff == WAIT_W'(1));
          end
        end
        ST_ACC: begin
          if (cnt == '0) begin
            rd_stb <= 1'b0;
            wr_stb <= 1'b0;
            done   <= 1'b0;
            if (trl_q == 2'd0) begin
              state  <= ST_IDLE;
              bus_cs <= 1'b0;
              busy   <= 1'b0;
            end else begin
              state <= ST_TRL;
              cnt   <= WAIT_W'(trl_q) - WAIT_W'(1);
            end
          end else begin
            cnt  <= cnt - WAIT_W'(1);
            done <= (cnt == WAIT_W'(1));
          end
        end
        ST_TRL: begin
          if (cnt == '0) begin
            state  <= ST_IDLE;
            bus_cs <= 1'b0;
            busy   <= 1'b0;
          end else begin
            cnt <= cnt - WAIT_W'(1);
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ext_wait_seq.sv
module ext_wait_seq #(
  parameter int WAIT_W    = 5,
  parameter int AREAS     = 2,
  parameter int ONE_TRAIL = 4,
  parameter int TWO_TRAIL = 8,
  localparam int CFG_W  = WAIT_W * AREAS,
  localparam int AREA_W = (AREAS > 1) ? $clog2(AREAS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [CFG_W-1:0]  cfg_wdata,
  output logic [CFG_W-1:0]  cfg_rdata,
  input  logic              req,
  input  logic [AREA_W-1:0] req_area,
  input  logic              req_write,
  input  logic              req_dram,
  output logic              bus_cs,
  output logic              rd_stb,
  output logic              wr_stb,
  output logic              done,
  output logic              busy,
  output logic              dram_fwd
);
  logic [WAIT_W-1:0] raw_wait;
  logic [WAIT_W-1:0] eff_wait;
  logic [1:0]        trail;

  ews_cfg_reg #(.WAIT_W(WAIT_W), .AREAS(AREAS)) u_cfg (
    .clk(clk), .rst(rst), .we(cfg_we), .wdata(cfg_wdata),
    .rdata(cfg_rdata), .sel(req_area), .sel_wait(raw_wait)
  );

  ews_wait_decode #(.WAIT_W(WAIT_W), .ONE_TRAIL(ONE_TRAIL), .TWO_TRAIL(TWO_TRAIL)) u_dec (
    .raw(raw_wait), .eff(eff_wait), .trail(trail)
  );

  ews_sequencer #(.WAIT_W(WAIT_W)) u_seq (
    .clk(clk), .rst(rst), .req(req), .req_write(req_write), .req_dram(req_dram),
    .eff(eff_wait), .trail(trail), .bus_cs(bus_cs), .rd_stb(rd_stb),
    .wr_stb(wr_stb), .done(done), .busy(busy), .dram_fwd(dram_fwd)
  );
endmodule

// File: rtl/ext_wait_seq_chk.sv
module ext_wait_seq_chk #(
  parameter int CFG_W = 10
) (
  input logic             clk,
  input logic             rst,
  input logic [CFG_W-1:0] cfg_rdata,
  input logic             bus_cs,
  input logic             rd_stb,
  input logic             wr_stb,
  input logic             done,
  input logic             busy,
  input logic             dram_fwd
);
  assert_reset_cfg_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (cfg_rdata == '1 && !busy && !bus_cs));

  assert_strobe_in_cs_R3: assert property (@(posedge clk) disable iff (rst)
    (rd_stb || wr_stb) |-> bus_cs);

  assert_one_strobe_R3: assert property (@(posedge clk) disable iff (rst)
    !(rd_stb && wr_stb));

  assert_done_with_strobe_R4: assert property (@(posedge clk) disable iff (rst)
    done |-> (rd_stb || wr_stb));

  assert_done_ends_strobe_R4: assert property (@(posedge clk) disable iff (rst)
    done |=> (!rd_stb && !wr_stb && !done));

  assert_cs_means_busy_R7: assert property (@(posedge clk) disable iff (rst)
    bus_cs == busy);

  assert_dram_idle_R9: assert property (@(posedge clk) disable iff (rst)
    dram_fwd |-> (!busy && !bus_cs));
endmodule

bind ext_wait_seq ext_wait_seq_chk #(.CFG_W(CFG_W)) u_chk (
  .clk(clk), .rst(rst), .cfg_rdata(cfg_rdata), .bus_cs(bus_cs),
  .rd_stb(rd_stb), .wr_stb(wr_stb), .done(done), .busy(busy),
  .dram_fwd(dram_fwd)
);

// File: tb/ext_wait_seq_tb.sv
module ext_wait_seq_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cfg_we = 1'b0;
  logic [9:0] cfg_wdata = '0;
  logic [9:0] cfg_rdata;
  logic       req = 1'b0;
  logic [0:0] req_area = 1'b0;
  logic       req_write = 1'b0;
  logic       req_dram = 1'b0;
  logic       bus_cs, rd_stb, wr_stb, done, busy, dram_fwd;
  int         errors = 0;
  int         checks = 0;
  logic [4:0] cur0 = 5'd31;
  logic [4:0] cur1 = 5'd31;

  always #5 clk = ~clk;

  ext_wait_seq u_dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .req(req), .req_area(req_area),
    .req_write(req_write), .req_dram(req_dram), .bus_cs(bus_cs),
    .rd_stb(rd_stb), .wr_stb(wr_stb), .done(done), .busy(busy),
    .dram_fwd(dram_fwd)
  );

  function automatic int exp_w(input logic [4:0] raw);
    return (raw == 5'd0) ? 1 : int'(raw);
  endfunction

  function automatic int exp_t(input int w);
    return (w >= 8) ? 2 : (w >= 4) ? 1 : 0;
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic set_cfg(input logic [4:0] a0, input logic [4:0] a1);
    cfg_we = 1'b1;
    cfg_wdata = {a1, a0};
    @(negedge clk);
    cfg_we = 1'b0;
    cur0 = a0;
    cur1 = a1;
  endtask

  task automatic measure(input bit mid_wr, input logic [9:0] mid_data,
                         output int cs_n, output int rd_n, output int wr_n,
                         output int done_n, output int done_at, output int busy_n);
    int i;
    cs_n = 0; rd_n = 0; wr_n = 0; done_n = 0; done_at = -1; busy_n = 0;
    i = 0;
    while (bus_cs === 1'b1 && i < 100) begin
      cs_n++;
      if (rd_stb) rd_n++;
      if (wr_stb) wr_n++;
      if (busy) busy_n++;
      if (done) begin done_n++; done_at = i; end
      if (i == 0 && mid_wr) begin
        cfg_we = 1'b1;
        cfg_wdata = mid_data;
      end else begin
        cfg_we = 1'b0;
      end
      i++;
      @(negedge clk);
    end
    cfg_we = 1'b0;
  endtask

  task automatic verify(input int w, input bit wr, input int cs_n, input int rd_n,
                        input int wr_n, input int done_n, input int done_at,
                        input int busy_n, input string tag);
    int t;
    t = exp_t(w);
    check((wr ? wr_n : rd_n) == w, {tag, " R3 strobe length"}, wr ? wr_n : rd_n, w);
    check((wr ? rd_n : wr_n) == 0, {tag, " R3 wrong strobe"}, wr ? rd_n : wr_n, 0);
    check(done_n == 1 && done_at == w - 1, {tag, " R4 done position"}, done_at, w - 1);
    check(cs_n == w + t, {tag, " R5 cs with trailing"}, cs_n, w + t);
    check(busy_n == cs_n, {tag, " R7 busy length"}, busy_n, cs_n);
  endtask

  task automatic run_access(input bit area, input bit wr, input string tag);
    int cs_n, rd_n, wr_n, done_n, done_at, busy_n;
    req = 1'b1; req_area = area; req_write = wr; req_dram = 1'b0;
    @(negedge clk);
    req = 1'b0;
    measure(1'b0, '0, cs_n, rd_n, wr_n, done_n, done_at, busy_n);
    verify(exp_w(area ? cur1 : cur0), wr, cs_n, rd_n, wr_n, done_n, done_at, busy_n, tag);
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int cs_n, rd_n, wr_n, done_n, done_at, busy_n;
    logic [4:0] dir [6];
    dir[0] = 5'd1; dir[1] = 5'd3; dir[2] = 5'd4;
    dir[3] = 5'd7; dir[4] = 5'd8; dir[5] = 5'd31;
    void'($urandom(32'd5309));

    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(cfg_rdata == 10'h3FF, "R1 reset cfg", int'(cfg_rdata), 10'h3FF);
    check({busy, bus_cs, rd_stb, wr_stb, done, dram_fwd} == 6'b0, "R1 reset outputs",
          int'({busy, bus_cs, rd_stb, wr_stb, done, dram_fwd}), 0);

    run_access(1'b1, 1'b0, "reset-31 area1");
    run_access(1'b0, 1'b1, "reset-31 area0");

    set_cfg(5'd9, 5'd22);
    check(cfg_rdata == {5'd22, 5'd9}, "R2 readback", int'(cfg_rdata), int'({5'd22, 5'd9}));

    foreach (dir[k]) begin
      set_cfg(dir[k], 5'd2);
      run_access(1'b0, 1'b0, $sformatf("area0 w=%0d", dir[k]));
      set_cfg(5'd2, dir[k]);
      run_access(1'b1, 1'b1, $sformatf("area1 w=%0d", dir[k]));
    end

    set_cfg(5'd0, 5'd0);
    req = 1'b1; req_area = 1'b0; req_write = 1'b0;
    @(negedge clk);
    req = 1'b0;
    measure(1'b0, '0, cs_n, rd_n, wr_n, done_n, done_at, busy_n);
    check(cs_n == 1 && rd_n == 1 && done_n == 1, "R6 zero clamp area0", cs_n, 1);
    @(negedge clk);
    run_access(1'b1, 1'b1, "R6 zero clamp area1");

    set_cfg(5'd3, 5'd3);
    req = 1'b1; req_area = 1'b0; req_write = 1'b0;
    @(negedge clk);
    req = 1'b0;
    measure(1'b1, {5'd3, 5'd9}, cs_n, rd_n, wr_n, done_n, done_at, busy_n);
    check(cs_n == 3 && rd_n == 3, "R8 write mid-access ignored", cs_n, 3);
    check(cfg_rdata == {5'd3, 5'd9}, "R8 write landed", int'(cfg_rdata), int'({5'd3, 5'd9}));
    cur0 = 5'd9;
    @(negedge clk);
    run_access(1'b0, 1'b0, "R8 new value next access");

    set_cfg(5'd5, 5'd2);
    req = 1'b1; req_area = 1'b0; req_write = 1'b1;
    @(negedge clk);
    measure(1'b0, '0, cs_n, rd_n, wr_n, done_n, done_at, busy_n);
    verify(5, 1'b1, cs_n, rd_n, wr_n, done_n, done_at, busy_n, "R7 held req ignored while busy");
    check(bus_cs == 1'b0 && busy == 1'b0, "R10 one idle cycle", int'(bus_cs), 0);
    @(negedge clk);
    req = 1'b0;
    check(bus_cs == 1'b1 && wr_stb == 1'b1, "R10 back-to-back accepted", int'(bus_cs), 1);
    measure(1'b0, '0, cs_n, rd_n, wr_n, done_n, done_at, busy_n);
    check(cs_n == 6 && wr_n == 5, "R10 second access length", cs_n, 6);
    @(negedge clk);

    req = 1'b1; req_dram = 1'b1; req_area = 1'b1;
    @(negedge clk);
    req = 1'b0; req_dram = 1'b0;
    check(dram_fwd == 1'b1, "R9 forward pulse", int'(dram_fwd), 1);
    check(!busy && !bus_cs && !rd_stb && !wr_stb, "R9 bus untouched",
          int'({busy, bus_cs, rd_stb, wr_stb}), 0);
    @(negedge clk);
    check(dram_fwd == 1'b0 && bus_cs == 1'b0, "R9 single cycle", int'(dram_fwd), 0);

    for (int n = 0; n < 40; n++) begin
      set_cfg(5'($urandom_range(0, 31)), 5'($urandom_range(0, 31)));
      run_access(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                 $sformatf("random #%0d", n));
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule